// File: doc/BRIEF.md
# Signed Multiply-Divide Coprocessor

This block is an arithmetic helper that software drives through three byte-wide registers. A selector picks the control/status register, an internal byte-address register, or a data window. Every access through the data window moves the internal address on by one, so software can stream a whole operand or result without rewriting the address.

Multiplication works on two 16-bit signed operands. The 32-bit signed product is combinational, so it can be read on the cycle after the last operand byte is written. Division takes a 32-bit signed dividend and a 16-bit signed divisor. A restoring divider works on the magnitudes and resolves one quotient bit per clock over 32 clocks, then applies the signs.

The divider is a two-state machine. In **IDLE** it holds the last results. The transition **IDLE→RUN** happens when software writes a 1 to control bit 0; the operands are latched and the done flag is cleared. In **RUN** there is one iteration per clock. On the 32nd iteration the transition **RUN→IDLE** happens: the results are committed and the done flag is set. A start request in RUN is ignored, so RUN→RUN also covers a start written during a division.

Top module: `muldiv_cop`

## Requirements
- R1: After reset the control/status register reads 0x02, the address register reads 0, and all quotient and remainder bytes read 0.
- R2: Selector 0 gives the control/status register as {5'b0, zero_div, done, busy}. Selector 1 gives the 4-bit address register, read as {4'b0, addr} and written from wdata[3:0]. Selector 2 gives the data window. Selector 3 reads 0 and ignores writes.
- R3: Each data-window read or write advances the address by one, and the address wraps from 15 to 0. A write to the address register takes priority.
- R4: Window bytes 0-1 hold multiplicand A and bytes 2-3 hold multiplier B, each most significant byte first. Bytes 4-7 read the signed 32-bit product A*B, most significant byte first, on the cycle after the last operand write.
- R5: Writes to bytes 8-11 load the dividend starting at bits [31:24]. Writes to bytes 12-13 load the divisor, high byte first. Reads of bytes 8-11 return the quotient and reads of bytes 12-13 return the remainder, both most significant byte first. Bytes 14-15 read 0. Writes to bytes 4-7, 14 and 15 are ignored.
- R6: A control write with wdata[0]=1 while idle starts a division. From the next clock, busy reads 1 and done reads 0.
- R7: Done returns to 1 and busy to 0 on exactly the 32nd clock edge after the start edge. The results change on that same edge and at no other time.
- R8: The quotient is truncated toward zero and the remainder takes the sign of the dividend. This includes -2^31 / -1, which gives a quotient of 0x80000000 and a remainder of 0.
- R9: A zero divisor sets zero_div at the start. The division still takes 32 clocks, then gives quotient 0xFFFFFFFF and a remainder equal to dividend[15:0]. The next start with a nonzero divisor clears zero_div.
- R10: While busy, a further start request is ignored, and operand writes do not change the division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the address when the data window is selected) |
| bus_sel | input | 2 | Register selector: 0 control/status, 1 address, 2 data window, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected register |

## Verification
The bench targets the sign corners of division. A divider that fixed the remainder sign from the divisor, or rounded toward minus infinity, would return wrong bytes for the mixed-sign cases. A divider that overflowed on -2^31 / -1 would also return wrong bytes. The bench also counts the divide latency every clock: a counter off by one would raise done a cycle early or late. For a zero divisor, a design that skipped the special case would return a zero remainder instead of the dividend's low half. Writing a restart and new dividend bytes in the middle of a division catches a design that re-latches its operands.

// File: rtl/cop_pkg.sv
package cop_pkg;
    localparam int OP_W  = 16;
    localparam int DD_W  = 32;
    localparam int AW    = 4;

    localparam logic [AW-1:0] BA_OPA  = 4'd0;
    localparam logic [AW-1:0] BA_OPB  = 4'd2;
    localparam logic [AW-1:0] BA_PROD = 4'd4;
    localparam logic [AW-1:0] BA_DVD  = 4'd8;
    localparam logic [AW-1:0] BA_DVS  = 4'd12;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_NONE = 2'd3;

    typedef enum logic {DS_IDLE, DS_RUN} div_state_t;
endpackage

// File: rtl/cop_port.sv
module cop_port
    import cop_pkg::*;
#(
    parameter int A_W = OP_W,
    parameter int N_W = DD_W,
    parameter int D_W = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           rd,
    input  logic [1:0]     sel,
    input  logic [7:0]     wdata,
    output logic [AW-1:0]  addr,
    output logic [A_W-1:0] opa,
    output logic [A_W-1:0] opb,
    output logic [N_W-1:0] dvd,
    output logic [D_W-1:0] dvs
);
    localparam int AB = A_W / 8;
    localparam int NB = N_W / 8;
    localparam int DB = D_W / 8;

    logic win_acc;
    assign win_acc = (sel == SEL_DATA) && (wr || rd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            opa  <= '0;
            opb  <= '0;
            dvd  <= '0;
            dvs  <= '0;
        end else begin
            if (wr && sel == SEL_ADDR)
                addr <= wdata[AW-1:0];
            else if (win_acc)
                addr <= addr + 1'b1;
            if (wr && sel == SEL_DATA) begin
                for (int i = 0; i < AB; i++) begin
                    if (addr == BA_OPA + AW'(i)) opa[A_W-1-8*i -: 8] <= wdata;
                    if (addr == BA_OPB + AW'(i)) opb[A_W-1-8*i -: 8] <= wdata;
                end
                for (int i = 0; i < NB; i++)
                    if (addr == BA_DVD + AW'(i)) dvd[N_W-1-8*i -: 8] <= wdata;
                for (int i = 0; i < DB; i++)
                    if (addr == BA_DVS + AW'(i)) dvs[D_W-1-8*i -: 8] <= wdata;
            end
        end
    end

    // R3: every window access steps the address by one, unless it is rewritten
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !(wr && sel == SEL_ADDR)) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/cop_mul.sv
module cop_mul #(
    parameter int A_W = 16,
    localparam int P_W = 2 * A_W
) (
    input  logic [A_W-1:0] a,
    input  logic [A_W-1:0] b,
    output logic [P_W-1:0] prod
);
    always_comb prod = P_W'($signed(a) * $signed(b));
endmodule

// File: rtl/cop_div.sv
module cop_div
    import cop_pkg::*;
#(
    parameter int N_W = DD_W,
    parameter int D_W = OP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dvd,
    input  logic [D_W-1:0] dvs,
    output logic           busy,
    output logic           done,
    output logic           zdiv,
    output logic [N_W-1:0] quo,
    output logic [D_W-1:0] rem
);
    localparam int CNT_W = $clog2(N_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_W - 1);

    div_state_t state, nxt_state;
    logic [CNT_W-1:0] cnt;
    logic [N_W-1:0]   work, nxt_work;
    logic [D_W-1:0]   part, nxt_part, dsr, low;
    logic [D_W:0]     shifted, diff;
    logic             ge, neg_q, neg_r;

    assign busy = (state == DS_RUN);

    always_comb begin
        shifted  = {part, work[N_W-1]};
        diff     = shifted - {1'b0, dsr};
        ge       = shifted >= {1'b0, dsr};
        nxt_part = ge ? diff[D_W-1:0] : shifted[D_W-1:0];
        nxt_work = {work[N_W-2:0], ge};
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            DS_IDLE: if (start) nxt_state = DS_RUN;
            DS_RUN:  if (cnt == LAST) nxt_state = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DS_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            work  <= '0;
            part  <= '0;
            dsr   <= '0;
            low   <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
            zdiv  <= 1'b0;
            done  <= 1'b1;
            quo   <= '0;
            rem   <= '0;
        end else begin
            unique case (state)
                DS_IDLE: if (start) begin
                    cnt   <= '0;
                    work  <= dvd[N_W-1] ? -dvd : dvd;
                    part  <= '0;
                    dsr   <= dvs[D_W-1] ? -dvs : dvs;
                    low   <= dvd[D_W-1:0];
                    neg_q <= dvd[N_W-1] ^ dvs[D_W-1];
                    neg_r <= dvd[N_W-1];
                    zdiv  <= (dvs == '0);
                    done  <= 1'b0;
                end
                DS_RUN: begin
                    cnt  <= cnt + 1'b1;
                    work <= nxt_work;
                    part <= nxt_part;
                    if (cnt == LAST) begin
                        done <= 1'b1;
                        quo  <= zdiv ? '1  : (neg_q ? -nxt_work : nxt_work);
                        rem  <= zdiv ? low : (neg_r ? -nxt_part : nxt_part);
                    end
                end
            endcase
        end
    end

    assert_start_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));
    assert_finish_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(done));
    assert_zero_div_quotient_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zdiv) |-> (quo == '1));
    assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/muldiv_cop.sv
module muldiv_cop
    import cop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int P_W = 2 * OP_W;

    logic [AW-1:0]   addr;
    logic [OP_W-1:0] opa, opb, dvs, rem;
    logic [DD_W-1:0] dvd, quo;
    logic [P_W-1:0]  prod;
    logic            busy, done, zdiv, start;
    logic [7:0]      win_byte;

    assign start = bus_wr && (bus_sel == SEL_CTRL) && bus_wdata[0];

    cop_port #(.A_W(OP_W), .N_W(DD_W), .D_W(OP_W)) u_port (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .sel(bus_sel),
        .wdata(bus_wdata), .addr(addr), .opa(opa), .opb(opb), .dvd(dvd), .dvs(dvs)
    );

    cop_mul #(.A_W(OP_W)) u_mul (.a(opa), .b(opb), .prod(prod));

    cop_div #(.N_W(DD_W), .D_W(OP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(start), .dvd(dvd), .dvs(dvs),
        .busy(busy), .done(done), .zdiv(zdiv), .quo(quo), .rem(rem)
    );

    always_comb begin
        win_byte = '0;
        for (int i = 0; i < OP_W / 8; i++) begin
            if (addr == BA_OPA + AW'(i)) win_byte = opa[OP_W-1-8*i -: 8];
            if (addr == BA_OPB + AW'(i)) win_byte = opb[OP_W-1-8*i -: 8];
            if (addr == BA_DVS + AW'(i)) win_byte = rem[OP_W-1-8*i -: 8];
        end
        for (int i = 0; i < P_W / 8; i++)
            if (addr == BA_PROD + AW'(i)) win_byte = prod[P_W-1-8*i -: 8];
        for (int i = 0; i < DD_W / 8; i++)
            if (addr == BA_DVD + AW'(i)) win_byte = quo[DD_W-1-8*i -: 8];
    end

    always_comb begin
        unique case (bus_sel)
            SEL_CTRL: bus_rdata = {5'b0, zdiv, done, busy};
            SEL_ADDR: bus_rdata = {{(8-AW){1'b0}}, addr};
            SEL_DATA: bus_rdata = win_byte;
            SEL_NONE: bus_rdata = 8'h00;
        endcase
    end

    assert_prod_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opa != '0 && opb != '0) |-> (prod[P_W-1] == (opa[OP_W-1] ^ opb[OP_W-1])));
endmodule

// File: tb/sim_muldiv_cop.sv
`timescale 1ns/1ps
module sim_muldiv_cop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int  n_chk = 0, n_fail = 0;
    bit  mon_on = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    muldiv_cop u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                   .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    // behavioural reference model
    logic [3:0]  m_addr;
    logic [15:0] m_a, m_b, m_dvs, m_r, p_r;
    logic [31:0] m_dvd, m_q, p_q;
    bit          m_busy, m_done, m_dz;
    int          m_left;

    function automatic logic [7:0] exp_byte(input logic [3:0] a);
        logic [31:0] p;
        p = 32'(longint'($signed(m_a)) * longint'($signed(m_b)));
        case (a)
            4'd0: return m_a[15:8];
            4'd1: return m_a[7:0];
            4'd2: return m_b[15:8];
            4'd3: return m_b[7:0];
            4'd4: return p[31:24];
            4'd5: return p[23:16];
            4'd6: return p[15:8];
            4'd7: return p[7:0];
            4'd8: return m_q[31:24];
            4'd9: return m_q[23:16];
            4'd10: return m_q[15:8];
            4'd11: return m_q[7:0];
            4'd12: return m_r[15:8];
            4'd13: return m_r[7:0];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        longint sa, sb;
        if (!rst_n) begin
            m_addr = 0; m_a = 0; m_b = 0; m_dvs = 0; m_dvd = 0;
            m_q = 0; m_r = 0; p_q = 0; p_r = 0;
            m_busy = 0; m_done = 1; m_dz = 0; m_left = 0;
        end else begin
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
                end
            end else if (bus_wr && bus_sel == 2'd0 && bus_wdata[0]) begin
                m_busy = 1; m_done = 0; m_left = 32; m_dz = (m_dvs == 0);
                if (m_dz) begin
                    p_q = 32'hFFFF_FFFF; p_r = m_dvd[15:0];
                end else begin
                    sa = longint'($signed(m_dvd));
                    sb = longint'($signed(m_dvs));
                    p_q = 32'(sa / sb);
                    p_r = 16'(sa % sb);
                end
            end
            if (bus_wr && bus_sel == 2'd1) m_addr = bus_wdata[3:0];
            else if (bus_sel == 2'd2 && (bus_wr || bus_rd)) begin
                if (bus_wr) case (m_addr)
                    4'd0: m_a[15:8] = bus_wdata;
                    4'd1: m_a[7:0] = bus_wdata;
                    4'd2: m_b[15:8] = bus_wdata;
                    4'd3: m_b[7:0] = bus_wdata;
                    4'd8: m_dvd[31:24] = bus_wdata;
                    4'd9: m_dvd[23:16] = bus_wdata;
                    4'd10: m_dvd[15:8] = bus_wdata;
                    4'd11: m_dvd[7:0] = bus_wdata;
                    4'd12: m_dvs[15:8] = bus_wdata;
                    4'd13: m_dvs[7:0] = bus_wdata;
                    default: ;
                endcase
                m_addr = m_addr + 4'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_on && !finished) begin
            case (bus_sel)
                2'd0: chk("R6/R7/R9 ctrl", bus_rdata, {5'b0, m_dz, m_done, m_busy});
                2'd1: chk("R3 addr", bus_rdata, {4'b0, m_addr});
                2'd2: chk("R4/R5 window", bus_rdata, exp_byte(m_addr));
                default: chk("R2 unused select", bus_rdata, 8'h00);
            endcase
        end
    end

    task automatic drv(input logic [1:0] s, input bit w, input bit r, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
    endtask
    task automatic idle();            drv(2'd0, 0, 0, 8'h00);      endtask
    task automatic set_addr(input logic [7:0] a); drv(2'd1, 1, 0, a); endtask
    task automatic wbyte(input logic [7:0] d);    drv(2'd2, 1, 0, d); endtask
    task automatic rbyte(output logic [7:0] v);
        drv(2'd2, 0, 1, 8'h00);
        @(negedge clk); v = bus_rdata;
    endtask
    task automatic rd_ctrl(output logic [7:0] v);
        idle(); @(negedge clk); v = bus_rdata;
    endtask

    task automatic load_mul(input logic [15:0] a, input logic [15:0] b);
        set_addr(8'd0);
        wbyte(a[15:8]); wbyte(a[7:0]); wbyte(b[15:8]); wbyte(b[7:0]);
    endtask

    task automatic check_prod(input logic [31:0] p, input string tag);
        logic [7:0] v;
        set_addr(8'd4);
        for (int i = 0; i < 4; i++) begin
            rbyte(v); chk(tag, v, p[31-8*i -: 8]);
        end
    endtask

    task automatic load_div(input logic [31:0] a, input logic [15:0] b);
        set_addr(8'd8);
        for (int i = 0; i < 4; i++) wbyte(a[31-8*i -: 8]);
        wbyte(b[15:8]); wbyte(b[7:0]);
    endtask

    task automatic check_res(input logic [31:0] q, input logic [15:0] r, input string tag);
        logic [7:0] v;
        set_addr(8'd8);
        for (int i = 0; i < 4; i++) begin rbyte(v); chk(tag, v, q[31-8*i -: 8]); end
        rbyte(v); chk(tag, v, r[15:8]);
        rbyte(v); chk(tag, v, r[7:0]);
    endtask

    task automatic run_div(input logic [31:0] a, input logic [15:0] b,
                           input logic [31:0] q, input logic [15:0] r, input string tag);
        logic [7:0] v;
        load_div(a, b);
        drv(2'd0, 1, 0, 8'h01);
        rd_ctrl(v); chk({tag, " R6 busy after start"}, v, {5'b0, (b == 0), 2'b01});
        repeat (31) idle();
        @(negedge clk); chk({tag, " R7 not done at 31"}, bus_rdata, {5'b0, (b == 0), 2'b01});
        rd_ctrl(v); chk({tag, " R7 done at 32"}, v, {5'b0, (b == 0), 2'b10});
        check_res(q, r, tag);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;

        // R1 reset state
        rd_ctrl(v); chk("R1 ctrl reset", v, 8'h02);
        drv(2'd1, 0, 0, 8'h00); @(negedge clk); chk("R1 addr reset", bus_rdata, 8'h00);
        check_res(32'h0, 16'h0, "R1 results reset");

        // R2 unused selector
        drv(2'd3, 1, 0, 8'hFF); @(negedge clk); chk("R2 sel3 reads zero", bus_rdata, 8'h00);

        // R4 multiply patterns
        load_mul(16'hFED4, 16'd1234);
        check_prod(32'(-370200), "R4 mul -300*1234");
        load_mul(16'h8000, 16'h8000);
        check_prod(32'h4000_0000, "R4 mul min*min");
        load_mul(16'h7FFF, 16'hFFFF);
        check_prod(32'(-32767), "R4 mul max*-1");
        load_mul(16'd0, 16'h1234);
        check_prod(32'h0, "R4 mul zero");
        load_mul(16'd25, 16'd4);

        // R5 ignored writes, R3 wraparound
        set_addr(8'd4); wbyte(8'hAA); wbyte(8'hBB);
        check_prod(32'd100, "R5 product write ignored");
        set_addr(8'd14); wbyte(8'h5A);
        set_addr(8'd14); rbyte(v); chk("R5 byte14 reads zero", v, 8'h00);
        set_addr(8'd15); rbyte(v);
        drv(2'd1, 0, 0, 8'h00); @(negedge clk); chk("R3 wrap to 0", bus_rdata, 8'h00);

        // R7/R8 signed division
        run_div(32'd100, 16'd7, 32'd14, 16'd2, "R8 +/+");
        run_div(32'(-100), 16'd7, 32'(-14), 16'(-2), "R8 -/+");
        run_div(32'd100, 16'(-7), 32'(-14), 16'd2, "R8 +/-");
        run_div(32'(-100), 16'(-7), 32'd14, 16'(-2), "R8 -/-");
        run_div(32'h8000_0000, 16'hFFFF, 32'h8000_0000, 16'd0, "R8 min/-1");
        run_div(32'd123456789, 16'h8000, 32'(-3767), 16'd19733, "R8 big/min");

        // R9 zero divisor, then cleared by a normal division
        run_div(32'(-7), 16'd0, 32'hFFFF_FFFF, 16'hFFF9, "R9 div by zero");
        run_div(32'd50, 16'd5, 32'd10, 16'd0, "R9 flag cleared");

        // R10 restart and operand writes during a division are ignored
        load_div(32'd100, 16'd7);
        drv(2'd0, 1, 0, 8'h01);
        repeat (3) idle();
        drv(2'd0, 1, 0, 8'h01);
        set_addr(8'd8);
        wbyte(8'h00); wbyte(8'h00); wbyte(8'h00); wbyte(8'h01);
        repeat (40) idle();
        @(negedge clk); chk("R10 finished once", bus_rdata, 8'h02);
        check_res(32'd14, 16'd2, "R10 operands latched");

        idle(); idle();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule